// File: doc/BRIEF.md
# Single-Correct Double-Detect Memory Protection Unit

This unit stands between a memory controller and a memory data path that is 72 bits wide. On the write side it takes a 64-bit word and passes it through unchanged. Next to the word it drives 8 check bits, and each check bit is the parity of a fixed subset of the data bits. On the read side it first captures the 72-bit codeword that comes back from memory. It then recomputes the check bits from the captured data and XORs them with the stored check bits to form an 8-bit syndrome. It returns the word to the controller with any single-bit error corrected, and it flags a double-bit error or any other pattern it cannot correct.

The code is an extended Hamming code with odd-weight columns. Every data-bit column holds an odd number of ones, at least three, and every check-bit column is a unit vector. A single flipped bit therefore always gives an odd-weight syndrome, and two flipped bits always give a nonzero even-weight syndrome. Read responses are registered and appear as a one-cycle valid pulse that carries two status flags.

Top module: `secded_unit`

## Requirements
- R1: Check bit j is the XOR of every data bit i whose column has bit j set. Columns are assigned in order. Data bits 0..55 take the 8-bit values that have exactly three ones, in ascending numeric order. Data bits 56..63 take the eight smallest 8-bit values that have exactly five ones, in ascending order.
- R2: One cycle after `wr_en` is sampled high, `mem_wr_en` is high, `mem_wr_data` equals the sampled `wr_data`, and `mem_wr_chk` holds its check bits per R1. Otherwise `mem_wr_en` is low.
- R3: A read sampled with `mem_rd_valid` high produces exactly one `rsp_valid` pulse two cycles later. Reads on consecutive cycles produce responses on consecutive cycles, in the same order.
- R4: If the syndrome (stored check bits XOR recomputed check bits) is zero, the data is returned unchanged and both flags are low.
- R5: If the syndrome equals the column of data bit i, that bit is inverted in `rsp_data` and `single_err` is high.
- R6: If the syndrome is a unit vector, meaning a check bit is in error, the data is returned unchanged and `single_err` is high.
- R7: If the syndrome is nonzero with even weight, `double_err` is high, `single_err` is low, and the data is returned uncorrected.
- R8: If the syndrome has odd weight but matches no column, `double_err` is high and the data is returned uncorrected. An example is the all-ones-but-one value with seven ones.
- R9: While `rst` is high and after it, until the first request, `rsp_valid`, `mem_wr_en`, `single_err` and `double_err` are low.
- R10: `single_err` and `double_err` are never high together, and both are low whenever `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write word valid from the controller |
| wr_data | input | 64 | Write word from the controller |
| mem_wr_en | output | 1 | Write codeword valid toward memory |
| mem_wr_data | output | 64 | Data part of the write codeword |
| mem_wr_chk | output | 8 | Check bits of the write codeword |
| mem_rd_valid | input | 1 | Read codeword valid from memory |
| mem_rd_data | input | 64 | Data part of the read codeword |
| mem_rd_chk | input | 8 | Stored check bits of the read codeword |
| rsp_valid | output | 1 | One-cycle response pulse toward the controller |
| rsp_data | output | 64 | Returned (possibly corrected) word |
| single_err | output | 1 | A correctable error was found and fixed |
| double_err | output | 1 | An uncorrectable error was found |

## Verification
The write codeword is due one cycle after `wr_en` is sampled. The bench drives each write on a falling edge and compares the outputs on the next falling edge against check bits it computes itself. A read response is due two rising edges after `mem_rd_valid` is sampled. The driver records the expected result and the due cycle in a scoreboard queue. A monitor samples on falling edges and flags any response that comes early, late, unexpected or with the wrong data or flags. Bursts of back-to-back reads cover all 72 single-bit flips, random double flips and an odd-weight syndrome that matches no column.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int CODE_W = DATA_W + CHK_W;

  // Column of data bit idx: odd-weight values (3, then 5, ...) in ascending order.
  function automatic logic [CHK_W-1:0] col_of(input int idx);
    logic [CHK_W-1:0] r;
    logic [CHK_W-1:0] v;
    int n;
    r = '0;
    n = 0;
    for (int w = 3; w <= CHK_W; w += 2) begin
      for (int k = 0; k < (1 << CHK_W); k++) begin
        v = k[CHK_W-1:0];
        if ($countones(v) == w) begin
          if (n == idx) r = v;
          n++;
        end
      end
    end
    return r;
  endfunction

  // Data bits feeding check bit j.
  function automatic logic [DATA_W-1:0] row_of(input int j);
    logic [DATA_W-1:0] m;
    logic [CHK_W-1:0]  c;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      c = col_of(i);
      m[i] = c[j];
    end
    return m;
  endfunction
endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] chk
);
  for (genvar j = 0; j < CW; j++) begin : g_row
    localparam logic [DW-1:0] ROW = row_of(j);
    assign chk[j] = ^(data & ROW);
  end
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [CW-1:0] syn,
  output logic [DW-1:0] flip,
  output logic          fixable,
  output logic          fatal
);
  logic chk_hit;

  for (genvar i = 0; i < DW; i++) begin : g_col
    localparam logic [CW-1:0] COL = col_of(i);
    assign flip[i] = (syn == COL);
  end

  assign chk_hit = $onehot(syn);
  assign fixable = (|flip) | chk_hit;
  assign fatal   = (|syn) & ~fixable;
endmodule

// File: rtl/secded_unit.sv
module secded_unit
  import secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          mem_wr_en,
  output logic [DW-1:0] mem_wr_data,
  output logic [CW-1:0] mem_wr_chk,
  input  logic          mem_rd_valid,
  input  logic [DW-1:0] mem_rd_data,
  input  logic [CW-1:0] mem_rd_chk,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          single_err,
  output logic          double_err
);
  // ---------------- write path ----------------
  logic [CW-1:0] wr_chk;

  secded_encoder #(.DW(DW), .CW(CW)) u_wr_enc (.data(wr_data), .chk(wr_chk));

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr_en   <= 1'b0;
      mem_wr_data <= '0;
      mem_wr_chk  <= '0;
    end else begin
      mem_wr_en <= wr_en;
      if (wr_en) begin
        mem_wr_data <= wr_data;
        mem_wr_chk  <= wr_chk;
      end
    end
  end

  // ---------------- read path: capture ----------------
  logic          rd_vld_q;
  logic [DW-1:0] rd_data_q;
  logic [CW-1:0] rd_chk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_q  <= 1'b0;
      rd_data_q <= '0;
      rd_chk_q  <= '0;
    end else begin
      rd_vld_q <= mem_rd_valid;
      if (mem_rd_valid) begin
        rd_data_q <= mem_rd_data;
        rd_chk_q  <= mem_rd_chk;
      end
    end
  end

  // ---------------- read path: syndrome and correction ----------------
  logic [CW-1:0] re_chk;
  logic [CW-1:0] syn;
  logic [DW-1:0] flip;
  logic          fixable;
  logic          fatal;

  secded_encoder #(.DW(DW), .CW(CW)) u_rd_enc (.data(rd_data_q), .chk(re_chk));
  assign syn = re_chk ^ rd_chk_q;
  secded_decoder #(.DW(DW), .CW(CW)) u_dec (
    .syn(syn), .flip(flip), .fixable(fixable), .fatal(fatal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      single_err <= 1'b0;
      double_err <= 1'b0;
    end else begin
      rsp_valid  <= rd_vld_q;
      single_err <= rd_vld_q & fixable;
      double_err <= rd_vld_q & fatal;
      if (rd_vld_q) rsp_data <= fatal ? rd_data_q : (rd_data_q ^ flip);
    end
  end

  // ---------------- assertions ----------------
  assert_wr_pass_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem_wr_en && mem_wr_data == $past(wr_data));

  assert_rsp_timing_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(rd_vld_q));

  assert_clean_pass_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !single_err && !double_err |-> rsp_data == $past(rd_data_q));

  assert_single_odd_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && single_err |-> ^$past(syn));

  assert_even_double_R7: assert property (@(posedge clk) disable iff (rst)
    rd_vld_q && (syn != '0) && !(^syn) |=> double_err && !single_err);

  assert_uncorr_keep_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && double_err |-> rsp_data == $past(rd_data_q));

  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(single_err && double_err));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !single_err && !double_err);
endmodule

// File: tb/secded_unit_test.sv
module secded_unit_test;
  localparam int DW = 64;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          mem_wr_en;
  logic [DW-1:0] mem_wr_data;
  logic [CW-1:0] mem_wr_chk;
  logic          mem_rd_valid = 1'b0;
  logic [DW-1:0] mem_rd_data = '0;
  logic [CW-1:0] mem_rd_chk = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          single_err;
  logic          double_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    logic [DW-1:0] data;
    logic          s;
    logic          d;
    int            due;
    string         req;
  } exp_t;
  exp_t sb[$];

  secded_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data), .mem_wr_chk(mem_wr_chk),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .mem_rd_chk(mem_rd_chk),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .single_err(single_err), .double_err(double_err)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference columns, built independently: count bits by hand.
  function automatic int nbits(input int v);
    int n = 0;
    for (int b = 0; b < CW; b++) if (v[b]) n++;
    return n;
  endfunction

  logic [CW-1:0] tb_col [DW];
  initial begin
    int n = 0;
    for (int v = 0; v < 256; v++) if (nbits(v) == 3 && n < DW) begin tb_col[n] = v[CW-1:0]; n++; end
    for (int v = 0; v < 256; v++) if (nbits(v) == 5 && n < DW) begin tb_col[n] = v[CW-1:0]; n++; end
  end

  function automatic logic [CW-1:0] tb_chk(input logic [DW-1:0] d);
    logic [CW-1:0] c = '0;
    for (int i = 0; i < DW; i++) if (d[i]) c ^= tb_col[i];
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: one read per call, called at a falling edge.
  task automatic send_read(input logic [DW+CW-1:0] code, input logic [DW-1:0] ed,
                           input logic es, input logic edbl, input string req);
    exp_t e;
    mem_rd_valid = 1'b1;
    mem_rd_data  = code[DW-1:0];
    mem_rd_chk   = code[DW+CW-1:DW];
    e.data = ed; e.s = es; e.d = edbl; e.due = cyc + 2; e.req = req;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (!rst) begin
      check(!(single_err && double_err), "R10", "flags both high", {63'b0, single_err}, {63'b0, double_err});
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3", "unexpected rsp_valid", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc == e.due, "R3", "response cycle", 64'(cyc), 64'(e.due));
          check(rsp_data == e.data, e.req, "rsp_data", rsp_data, e.data);
          check(single_err == e.s, e.req, "single_err", {63'b0, single_err}, {63'b0, e.s});
          check(double_err == e.d, e.req, "double_err", {63'b0, double_err}, {63'b0, e.d});
        end
      end else begin
        check(!single_err && !double_err, "R10", "flags while idle", {63'b0, single_err | double_err}, 64'd0);
        if (sb.size() != 0 && sb[0].due < cyc) begin
          check(1'b0, "R3", "missing response", 64'(cyc), 64'(sb[0].due));
          void'(sb.pop_front());
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 64'(cyc), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [DW+CW-1:0] code, bad;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!rsp_valid && !mem_wr_en && !single_err && !double_err, "R9", "outputs in reset",
          {60'b0, rsp_valid, mem_wr_en, single_err, double_err}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!rsp_valid && !mem_wr_en, "R9", "outputs after reset", {62'b0, rsp_valid, mem_wr_en}, 64'd0);

    // R1 / R2: write path
    for (int t = 0; t < 12; t++) begin
      case (t)
        0: d = '0;
        1: d = '1;
        2: d = 64'h1;
        3: d = 64'h8000_0000_0000_0000;
        default: d = {$urandom, $urandom};
      endcase
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = ~d;
      check(mem_wr_en && mem_wr_data == d, "R2", "write data", mem_wr_data, d);
      check(mem_wr_chk == tb_chk(d), "R1", "check bits", {56'b0, mem_wr_chk}, {56'b0, tb_chk(d)});
      @(negedge clk);
      check(!mem_wr_en, "R2", "write enable drop", {63'b0, mem_wr_en}, 64'd0);
    end

    // R4: clean codewords, back to back (R3 ordering)
    for (int t = 0; t < 8; t++) begin
      d = (t == 0) ? '0 : {$urandom, $urandom};
      send_read({tb_chk(d), d}, d, 1'b0, 1'b0, "R4");
    end
    // R5 / R6: every single-bit flip
    for (int p = 0; p < DW + CW; p++) begin
      d = {$urandom, $urandom};
      code = {tb_chk(d), d};
      bad = code ^ ((DW+CW)'(1) << p);
      send_read(bad, d, 1'b1, 1'b0, (p < DW) ? "R5" : "R6");
    end
    mem_rd_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R7: random double flips
    for (int t = 0; t < 48; t++) begin
      int a, b;
      a = $urandom_range(DW+CW-1, 0);
      b = $urandom_range(DW+CW-1, 0);
      if (b == a) b = (a + 1) % (DW + CW);
      d = {$urandom, $urandom};
      code = {tb_chk(d), d};
      bad = code ^ ((DW+CW)'(1) << a) ^ ((DW+CW)'(1) << b);
      send_read(bad, bad[DW-1:0], 1'b0, 1'b1, "R7");
      mem_rd_valid = 1'b0;
      @(negedge clk);
    end
    // R8: seven check bits flipped -> odd syndrome with no column
    d = 64'h0123_4567_89AB_CDEF;
    code = {tb_chk(d) ^ 8'h7F, d};
    send_read(code, d, 1'b0, 1'b1, "R8");
    mem_rd_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R3", "all responses returned", 64'(sb.size()), 64'd0);
    check(!rsp_valid, "R3", "single pulse", {63'b0, rsp_valid}, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule